// File: doc/BRIEF.md
# Reloading Up/Down Event Counter

This block is one channel of a 16-bit timer running in event-counting mode. It counts transitions on an external event input while software has set a start flag. A small mode register chooses the transition polarity that counts. It also chooses whether the count direction comes from a software flag or from the level of a secondary pin, and whether that pin is driven as a toggling output. The secondary pin is modelled as a separate input level, output level and output enable.

When a decrementing count is at 0000h and another event arrives, or an incrementing count is at FFFFh and another event arrives, the channel reloads itself from a reload register. It also sets a sticky interrupt request and, in pulse mode, inverts its output level. It then carries on counting. Software programs the channel through a four-address write port and can always observe the live count.

Top module: `event_tally_timer`

## Requirements
- R1: The channel counts only while the mode register (address 0, wr_data[5:0]) has bits [1:0] = 01 and bit 5 = 0. With any other mode value the count holds.
- R2: Control register (address 1): wr_data[1] is the start flag and wr_data[0] is the up-down flag. While the start flag is 0, event transitions leave the count unchanged.
- R3: Mode bit 3 = 0 counts falling transitions of evt_in. Mode bit 3 = 1 counts rising transitions. The other transition polarity is never counted.
- R4: With mode bit 4 = 0, an up-down flag of 1 increments the count on each event and a flag of 0 decrements it.
- R5: With mode bit 4 = 1 and mode bit 2 = 0, the level of dir_pin_in sets the direction: high increments and low decrements.
- R6: An event that arrives when a decrementing count is 0000h, or when an incrementing count is FFFFh, loads the count from the reload register (address 2) and sets irq_req. The count keeps running afterwards.
- R7: dir_pin_oe equals mode bit 2. When mode bit 2 = 1, dir_pin_out inverts at every R6 terminal event. Otherwise dir_pin_out keeps its level.
- R8: When mode bits 2 and 4 are both 1, the direction comes from the up-down flag and dir_pin_in is ignored.
- R9: evt_in and dir_pin_in pass through two synchronizer flops. A transition applied before clock edge k changes count_q at edge k+2. There is at most one count step per clock.
- R10: A reload write while the start flag is 0 also loads the count. A reload write while it is 1 changes only the value used at the next terminal event.
- R11: irq_req stays set until a write to address 3 with wr_data[0] = 0. Writing wr_data[0] = 1 there has no effect. A terminal event in the same cycle as a clear leaves irq_req set.
- R12: A synchronous reset clears count_q, the reload value, mode, flags, irq_req, dir_pin_out and dir_pin_oe to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 1 | External event input (asynchronous) |
| dir_pin_in | input | 1 | Level of secondary pin, used as a direction source |
| dir_pin_out | output | 1 | Toggle level driven on secondary pin |
| dir_pin_oe | output | 1 | Output enable of secondary pin (mode bit 2) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 mode, 1 control, 2 reload, 3 interrupt clear |
| wr_data | input | 16 | Register write data |
| count_q | output | 16 | Live counter value |
| irq_req | output | 1 | Sticky interrupt request |

## Verification
The hardest situation to reach is an interrupt clear that lands in the same clock as a terminal event. The event passes through two synchronizer stages before it reaches the counter, so the stimulus raises evt_in on a falling clock edge with the count parked at 0000h and decrementing. It then places the clear write so that it spans exactly the second rising edge after that. The same timed sequence also checks the two-edge synchronizer latency, by sampling the count after each of the three edges.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int MODE_W = 6;
  localparam int MB_SEL0  = 0;
  localparam int MB_SEL1  = 1;
  localparam int MB_PULSE = 2;
  localparam int MB_RISE  = 3;
  localparam int MB_PIN   = 4;
  localparam int MB_RSV   = 5;

  typedef enum logic [1:0] {
    A_MODE   = 2'd0,
    A_CTRL   = 2'd1,
    A_RELOAD = 2'd2,
    A_IRQ    = 2'd3
  } reg_addr_e;

  function automatic logic mode_ok(input logic [MODE_W-1:0] m);
    return (m[MB_SEL1:MB_SEL0] == 2'b01) && !m[MB_RSV];
  endfunction
endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic evt_in,
  input  logic lvl_in,
  output logic rise_p,
  output logic fall_p,
  output logic lvl_s
);
  logic [STAGES-1:0] evt_sh;
  logic [STAGES-1:0] lvl_sh;
  logic              evt_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_sh   <= '0;
      lvl_sh   <= '0;
      evt_prev <= 1'b0;
    end else begin
      evt_sh   <= {evt_sh[STAGES-2:0], evt_in};
      lvl_sh   <= {lvl_sh[STAGES-2:0], lvl_in};
      evt_prev <= evt_sh[STAGES-1];
    end
  end

  assign rise_p = evt_sh[STAGES-1] & ~evt_prev;
  assign fall_p = ~evt_sh[STAGES-1] & evt_prev;
  assign lvl_s  = lvl_sh[STAGES-1];
endmodule

// File: rtl/evt_regs.sv
module evt_regs
  import evt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [MODE_W-1:0] mode_r,
  output logic              start_r,
  output logic              ud_r,
  output logic [CNT_W-1:0]  reload_r,
  output logic              reload_wr,
  output logic              irq_clr
);
  logic sel_mode, sel_ctrl;

  assign sel_mode  = wr_en && (wr_addr == A_MODE);
  assign sel_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign reload_wr = wr_en && (wr_addr == A_RELOAD);
  assign irq_clr   = wr_en && (wr_addr == A_IRQ) && !wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r   <= '0;
      start_r  <= 1'b0;
      ud_r     <= 1'b0;
      reload_r <= '0;
    end else begin
      if (sel_mode)  mode_r   <= wr_data[MODE_W-1:0];
      if (sel_ctrl) begin
        ud_r    <= wr_data[0];
        start_r <= wr_data[1];
      end
      if (reload_wr) reload_r <= wr_data;
    end
  end
endmodule

// File: rtl/evt_core.sv
module evt_core
  import evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_r,
  input  logic              start_r,
  input  logic              ud_r,
  input  logic [CNT_W-1:0]  reload_r,
  input  logic              reload_wr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              irq_clr,
  input  logic              rise_p,
  input  logic              fall_p,
  input  logic              lvl_s,
  output logic [CNT_W-1:0]  count_q,
  output logic              irq_q,
  output logic              tog_q
);
  localparam logic [CNT_W-1:0] TOP_VAL = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] BOT_VAL = '0;

  logic step, go_up, term, load_now;

  always_comb begin
    step = start_r && mode_ok(mode_r) && (mode_r[MB_RISE] ? rise_p : fall_p);
    if (mode_r[MB_PULSE])    go_up = ud_r;
    else if (mode_r[MB_PIN]) go_up = lvl_s;
    else                     go_up = ud_r;
    term     = step && (go_up ? (count_q == TOP_VAL) : (count_q == BOT_VAL));
    load_now = reload_wr && !start_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      irq_q   <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      if (load_now)  count_q <= wr_data;
      else if (term) count_q <= reload_r;
      else if (step) count_q <= go_up ? count_q + 1'b1 : count_q - 1'b1;

      if (term)         irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;

      if (term && mode_r[MB_PULSE]) tog_q <= ~tog_q;
    end
  end
endmodule

// File: rtl/event_tally_timer.sv
module event_tally_timer
  import evt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_in,
  input  logic              dir_pin_in,
  output logic              dir_pin_out,
  output logic              dir_pin_oe,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  count_q,
  output logic              irq_req
);
  logic [MODE_W-1:0] mode_r;
  logic              start_r, ud_r, reload_wr, irq_clr;
  logic [CNT_W-1:0]  reload_r;
  logic              rise_p, fall_p, lvl_s;

  evt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .evt_in(evt_in), .lvl_in(dir_pin_in),
    .rise_p(rise_p), .fall_p(fall_p), .lvl_s(lvl_s)
  );

  evt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_r(mode_r), .start_r(start_r), .ud_r(ud_r), .reload_r(reload_r),
    .reload_wr(reload_wr), .irq_clr(irq_clr)
  );

  evt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .mode_r(mode_r), .start_r(start_r), .ud_r(ud_r),
    .reload_r(reload_r), .reload_wr(reload_wr), .wr_data(wr_data),
    .irq_clr(irq_clr), .rise_p(rise_p), .fall_p(fall_p), .lvl_s(lvl_s),
    .count_q(count_q), .irq_q(irq_req), .tog_q(dir_pin_out)
  );

  assign dir_pin_oe = mode_r[MB_PULSE];
endmodule

// File: rtl/evt_checker.sv
module evt_checker
  import evt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CNT_W-1:0]  wr_data,
  input logic [MODE_W-1:0] mode_r,
  input logic              start_r,
  input logic [CNT_W-1:0]  reload_r,
  input logic [CNT_W-1:0]  count_q,
  input logic              irq_req,
  input logic              dir_pin_out
);
  logic rl_wr, clr_wr;
  assign rl_wr  = wr_en && (wr_addr == A_RELOAD);
  assign clr_wr = wr_en && (wr_addr == A_IRQ) && !wr_data[0];

  // R1
  a_r1_bad_mode_holds: assert property (@(posedge clk) disable iff (rst)
    (!mode_ok(mode_r) && !rl_wr) |=> $stable(count_q));
  // R2
  a_r2_stopped_holds: assert property (@(posedge clk) disable iff (rst)
    (!start_r && !rl_wr) |=> $stable(count_q));
  // R6
  a_r6_irq_brings_reload: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> (count_q == $past(reload_r)));
  // R7
  a_r7_toggle_needs_pulse: assert property (@(posedge clk) disable iff (rst)
    (dir_pin_out != $past(dir_pin_out)) |-> $past(mode_r[MB_PULSE]));
  // R11
  a_r11_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !clr_wr) |=> irq_req);
endmodule

bind event_tally_timer evt_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .mode_r(mode_r), .start_r(start_r), .reload_r(reload_r), .count_q(count_q),
  .irq_req(irq_req), .dir_pin_out(dir_pin_out)
);

// File: tb/tb_event_tally_timer.sv
module tb_event_tally_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_in = 1'b0;
  logic        dir_pin_in = 1'b0;
  logic        dir_pin_out, dir_pin_oe;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [15:0] count_q;
  logic        irq_req;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  event_tally_timer dut (
    .clk(clk), .rst(rst), .evt_in(evt_in), .dir_pin_in(dir_pin_in),
    .dir_pin_out(dir_pin_out), .dir_pin_oe(dir_pin_oe), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .count_q(count_q), .irq_req(irq_req)
  );

  // {mode[7:0], ud, pin, reload[15:0], pulses[7:0], exp_cnt[15:0], exp_irq, exp_tog}
  localparam int NV = 11;
  localparam logic [51:0] VECS [0:NV-1] = '{
    {8'h01, 1'b0, 1'b0, 16'h0005, 8'd3, 16'h0002, 1'b0, 1'b0}, // R4 down
    {8'h01, 1'b1, 1'b0, 16'h0010, 8'd4, 16'h0014, 1'b0, 1'b0}, // R4 up
    {8'h05, 1'b0, 1'b0, 16'h0002, 8'd3, 16'h0002, 1'b1, 1'b1}, // R6 underflow, R7
    {8'h05, 1'b1, 1'b0, 16'hFFFE, 8'd2, 16'hFFFE, 1'b1, 1'b1}, // R6 overflow, R7
    {8'h11, 1'b0, 1'b1, 16'h0100, 8'd3, 16'h0103, 1'b0, 1'b0}, // R5 pin high
    {8'h11, 1'b1, 1'b0, 16'h0100, 8'd3, 16'h00FD, 1'b0, 1'b0}, // R5 pin low
    {8'h09, 1'b0, 1'b0, 16'h0008, 8'd2, 16'h0006, 1'b0, 1'b0}, // R3 rising
    {8'h03, 1'b1, 1'b0, 16'h0007, 8'd3, 16'h0007, 1'b0, 1'b0}, // R1 bits[1:0]=11
    {8'h21, 1'b1, 1'b0, 16'h0007, 8'd3, 16'h0007, 1'b0, 1'b0}, // R1 bit5
    {8'h15, 1'b1, 1'b0, 16'h0010, 8'd2, 16'h0012, 1'b0, 1'b0}, // R8
    {8'h05, 1'b0, 1'b0, 16'h0000, 8'd3, 16'h0000, 1'b1, 1'b1}  // R6 reload 0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); evt_in = 1'b1;
    repeat (4) @(negedge clk);
    evt_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; evt_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R12 count", count_q, 0);
    check("R12 irq", irq_req, 0);
    check("R12 tog", dir_pin_out, 0);
    check("R12 oe", dir_pin_oe, 0);

    for (int i = 0; i < NV; i++) begin
      logic [51:0] v;
      v = VECS[i];
      do_reset();
      dir_pin_in = v[42];
      wr(2'd0, {8'h00, v[51:44]});
      wr(2'd1, {15'd0, v[43]});
      wr(2'd2, v[41:26]);
      wr(2'd1, {14'd0, 1'b1, v[43]});
      repeat (8) @(negedge clk);
      for (int p = 0; p < int'(v[25:18]); p++) pulse();
      check($sformatf("R1-vector%0d count (R4 R5 R6 R8)", i), count_q, v[17:2]);
      check($sformatf("R6 vector%0d irq", i), irq_req, v[1]);
      check($sformatf("R7 vector%0d tog", i), dir_pin_out, v[0]);
      check($sformatf("R7 vector%0d oe", i), dir_pin_oe, v[46]);
    end

    // R2: stopped channel ignores events
    do_reset();
    wr(2'd0, 16'h0001); wr(2'd1, 16'h0001); wr(2'd2, 16'h0003);
    pulse(); pulse();
    check("R2 stopped count", count_q, 16'h0003);

    // R3: falling mode ignores rise, counts fall
    wr(2'd1, 16'h0003);
    @(negedge clk); evt_in = 1'b1;
    repeat (5) @(negedge clk);
    check("R3 rise ignored in falling mode", count_q, 16'h0003);
    evt_in = 1'b0;
    repeat (5) @(negedge clk);
    check("R3 fall counted", count_q, 16'h0004);
    wr(2'd0, 16'h0009);
    @(negedge clk); evt_in = 1'b1;
    repeat (5) @(negedge clk);
    check("R3 rise counted", count_q, 16'h0005);
    evt_in = 1'b0;
    repeat (5) @(negedge clk);
    check("R3 fall ignored in rising mode", count_q, 16'h0005);

    // R9 latency and R11 priority of terminal over clear
    do_reset();
    wr(2'd0, 16'h0009); wr(2'd1, 16'h0000); wr(2'd2, 16'h0000);
    wr(2'd1, 16'h0002);
    repeat (3) @(negedge clk);
    evt_in = 1'b1;                       // before edge E0
    @(negedge clk);                      // after E0
    check("R9 no change after E0", count_q, 16'h0000);
    check("R9 irq after E0", irq_req, 0);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'h0000; // clear spans E1 only
    @(negedge clk);                      // after E1
    check("R9 no change after E1", count_q, 16'h0000);
    check("R9 irq after E1", irq_req, 0);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'h0000; // clear spans E2 with terminal
    @(negedge clk);                      // after E2
    wr_en = 1'b0;
    check("R11 terminal wins over clear", irq_req, 1);
    check("R9 reload at E2", count_q, 16'h0000);
    wr(2'd3, 16'h0001);
    @(negedge clk);
    check("R11 write 1 has no effect", irq_req, 1);
    wr(2'd3, 16'h0000);
    @(negedge clk);
    check("R11 clear", irq_req, 0);
    evt_in = 1'b0;
    repeat (4) @(negedge clk);

    // R10: reload write while running
    do_reset();
    wr(2'd0, 16'h0001); wr(2'd1, 16'h0000); wr(2'd2, 16'h0001);
    check("R10 stopped write loads count", count_q, 16'h0001);
    wr(2'd1, 16'h0002);
    wr(2'd2, 16'h0005);
    @(negedge clk);
    check("R10 running write keeps count", count_q, 16'h0001);
    pulse();
    check("R10 step to zero", count_q, 16'h0000);
    pulse();
    check("R10 new reload used", count_q, 16'h0005);
    check("R6 irq after underflow", irq_req, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule